// File: doc/BRIEF.md
# Area-Based Chip Select Generator

This block drives eight active-low chip select lines for an external memory bus, one line for each of eight equal address areas. The area of a bus cycle comes from the top three bits of a 24-bit address. A line goes low only while a bus cycle runs to external memory in its own area, and only when the device works in expanded mode. Cycles that reach on-chip ROM, on-chip RAM or internal registers never assert any line.

Each pin also has an output-enable. When the output-enable is low, the pin is left as an input. Lines 0 to 3 are enabled by one 4-bit register group, and lines 4 to 7 by a second 4-bit group. The values that the groups take at reset depend on whether on-chip ROM is in use. This lets the boot area drive its select line straight away when the device boots from external memory.

Top module: `area_cs_gen`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets every cs_n bit high. It loads the low enable group with 4'b0001 when rom_on is 0 and with 4'b0000 when rom_on is 1. It clears the high enable group to 0.
- R2: With bus_strobe high, int_target low and expanded high at a clock edge, and area k = addr_top enabled, cs_n[k] is low after that edge and every other cs_n bit is high.
- R3: After a clock edge with bus_strobe low, every cs_n bit is high.
- R4: After a clock edge with int_target high, every cs_n bit is high, whatever the address and strobe.
- R5: A write with en_lo_we high loads en_wdata into the low group. Bit i enables line i, for i from 0 to 3.
- R6: A write with en_hi_we high loads en_wdata into the high group. Bit i enables line 4+i.
- R7: In expanded mode, cs_oe equals the concatenation {high group, low group}. A line whose enable bit is 0 has cs_oe low and cs_n high, even when its area is addressed.
- R8: With expanded low, every cs_oe bit is low and every cs_n bit is high, whatever the register contents and bus inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| expanded | input | 1 | 1 = expanded mode, 0 = single-chip mode |
| rom_on | input | 1 | 1 = on-chip ROM in use; selects the reset default of the low group |
| bus_strobe | input | 1 | High during a bus cycle |
| addr_top | input | 3 | Address bits 23:21, which give the area index |
| int_target | input | 1 | High when the cycle targets on-chip memory or registers |
| en_lo_we | input | 1 | Write strobe for the enables of lines 0 to 3 |
| en_hi_we | input | 1 | Write strobe for the enables of lines 4 to 7 |
| en_wdata | input | 4 | Enable write data |
| cs_n | output | 8 | Active-low chip selects, registered |
| cs_oe | output | 8 | Per-pin output-enable |

## Verification
Area decoding is tried by walking a strobed external cycle through all eight areas with every line enabled. This shows that each address value selects its own line and no other. The same strobed cycle is then repeated with one condition changed each time: the internal-target flag raised, the strobe dropped, the enable of the addressed line cleared, or the mode set to single-chip. Each of these must leave every line high, and comparing them separates the cause of each suppression. Reset is checked with rom_on both 0 and 1, and an area 0 access follows each reset. This tells apart the two default enable states of the boot line.

// File: rtl/area_cs_gen.sv
module area_cs_gen #(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W    = 24
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        expanded,
  input  logic                                        rom_on,
  input  logic                                        bus_strobe,
  input  logic [ADDR_W-1:ADDR_W-$clog2(NUM_AREAS)]    addr_top,
  input  logic                                        int_target,
  input  logic                                        en_lo_we,
  input  logic                                        en_hi_we,
  input  logic [NUM_AREAS/2-1:0]                      en_wdata,
  output logic [NUM_AREAS-1:0]                        cs_n,
  output logic [NUM_AREAS-1:0]                        cs_oe
);
  localparam int SEL_W = $clog2(NUM_AREAS);
  localparam int GRP_W = NUM_AREAS / 2;

  logic [GRP_W-1:0]     en_lo, en_hi;
  logic [NUM_AREAS-1:0] en, hit, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_lo <= rom_on ? '0 : GRP_W'(1);
      en_hi <= '0;
    end else begin
      if (en_lo_we) en_lo <= en_wdata;
      if (en_hi_we) en_hi <= en_wdata;
    end
  end

  assign en = {en_hi, en_lo};

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    assign hit[i] = bus_strobe && !int_target && expanded &&
                    (addr_top == SEL_W'(i));

    // R2
    decode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> ($past(addr_top) == SEL_W'(i)) && $past(bus_strobe));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cs_q <= '1;
    else        cs_q <= ~(hit & en);
  end

  assign cs_oe = expanded ? en : '0;
  assign cs_n  = cs_q | ~cs_oe;

  // R2
  single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_strobe) |-> &cs_n);

  // R4
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(int_target) |-> &cs_n);

  // R7
  disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~cs_oe & ~cs_n) == '0);

  // R8
  single_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !expanded |-> (cs_oe == '0) && (&cs_n));
endmodule

// File: tb/area_cs_gen_tb_top.sv
module area_cs_gen_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       expanded = 1;
  logic       rom_on = 0;
  logic       bus_strobe = 0;
  logic [2:0] addr_top = '0;
  logic       int_target = 0;
  logic       en_lo_we = 0;
  logic       en_hi_we = 0;
  logic [3:0] en_wdata = '0;
  logic [7:0] cs_n, cs_oe;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  area_cs_gen dut_i (
    .clk(clk), .rst_n(rst_n), .expanded(expanded), .rom_on(rom_on),
    .bus_strobe(bus_strobe), .addr_top(addr_top), .int_target(int_target),
    .en_lo_we(en_lo_we), .en_hi_we(en_hi_we), .en_wdata(en_wdata),
    .cs_n(cs_n), .cs_oe(cs_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic rom);
    @(negedge clk);
    rom_on = rom; rst_n = 0; bus_strobe = 0; int_target = 0;
    step(); step();
    @(negedge clk); rst_n = 1;
    chk("R1 cs_n", cs_n, 8'hFF);
    chk("R1 cs_oe", cs_oe, rom ? 8'h00 : 8'h01);
  endtask

  task automatic write_grp(input logic hi, input logic [3:0] d);
    @(negedge clk);
    en_lo_we = !hi; en_hi_we = hi; en_wdata = d;
    step();
    @(negedge clk); en_lo_we = 0; en_hi_we = 0;
  endtask

  task automatic access(input logic [2:0] a, input logic intl, output logic [7:0] got);
    @(negedge clk);
    addr_top = a; int_target = intl; bus_strobe = 1;
    step();
    got = cs_n;
    @(negedge clk); bus_strobe = 0; int_target = 0;
  endtask

  task automatic t_reset_defaults();
    logic [7:0] g;
    do_reset(0);
    access(3'd0, 0, g); chk("R1 boot line drives", g, 8'hFE);
    do_reset(1);
    access(3'd0, 0, g); chk("R1 rom on no drive", g, 8'hFF);
  endtask

  task automatic t_decode_walk();
    logic [7:0] g;
    write_grp(0, 4'hF); write_grp(1, 4'hF);
    chk("R5 R6 enables", cs_oe, 8'hFF);
    for (int k = 0; k < 8; k++) begin
      access(k[2:0], 0, g);
      chk("R2 decode", g, ~(8'h01 << k));
    end
  endtask

  task automatic t_release();
    logic [7:0] g;
    access(3'd6, 0, g); chk("R2 area 6", g, 8'hBF);
    step(); chk("R3 release", cs_n, 8'hFF);
  endtask

  task automatic t_internal();
    logic [7:0] g;
    access(3'd2, 1, g); chk("R4 internal", g, 8'hFF);
    access(3'd0, 1, g); chk("R4 internal area0", g, 8'hFF);
  endtask

  task automatic t_disable();
    logic [7:0] g;
    write_grp(1, 4'b0010);
    chk("R6 high group", cs_oe, 8'h2F);
    access(3'd5, 0, g); chk("R6 line5 on", g, 8'hDF);
    access(3'd4, 0, g); chk("R7 line4 off", g, 8'hFF);
    write_grp(0, 4'b1010);
    chk("R5 low group", cs_oe, 8'h2A);
    access(3'd2, 0, g); chk("R7 line2 off", g, 8'hFF);
    access(3'd3, 0, g); chk("R5 line3 on", g, 8'hF7);
  endtask

  task automatic t_single_chip();
    logic [7:0] g;
    write_grp(0, 4'hF); write_grp(1, 4'hF);
    @(negedge clk); expanded = 0; #1;
    chk("R8 oe", cs_oe, 8'h00);
    access(3'd1, 0, g); chk("R8 cs", g, 8'hFF);
    @(negedge clk); expanded = 1;
    access(3'd1, 0, g); chk("R2 back expanded", g, 8'hFD);
  endtask

  initial begin
    t_reset_defaults();
    t_decode_walk();
    t_release();
    t_internal();
    t_disable();
    t_single_chip();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule